// File: doc/BRIEF.md
# Translation Lookaside Buffer with Protected Entries

This block is a small fully associative address translation cache. Each slot stores a page tag taken from the upper virtual address bits, a physical page number, a valid flag and a protect flag. A lookup port translates a virtual address in the same cycle. A refill port installs a new translation, and a command port runs one of two flush operations, acknowledged by a one-cycle done pulse.

The two flush operations treat protected slots differently. The flush-all operation sweeps away every unprotected translation and leaves protected ones in place. The targeted flush takes an address and removes the translation that matches it even when that translation is protected. This lets software pin critical mappings across context switches and still retire them one at a time.

Matching uses a 1 KB granule. A page whose subpages carry different permissions therefore sits in the buffer as four separate slots, and each one needs its own targeted flush. Refill places a new translation in the lowest free slot. When no slot is free it replaces a slot through a rotating pointer that skips protected slots. When every slot is protected, the refill is refused and flagged.

Top module: `tlb_preserve`

## Requirements
- R1: After reset no lookup hits, cmd_done and rf_fail are low, and every slot is free and unprotected, so the first ENTRIES refills all succeed.
- R2: A lookup is combinational. On a hit, lk_hit is 1 and lk_paddr is {ppn, lk_vaddr[9:0]}. On a miss, lk_hit is 0 and lk_paddr is 0.
- R3: Only address bits [31:10] take part in matching. Any address inside the same 1 KB granule hits, and the next granule misses.
- R4: A command with cmd_op=0 (flush-all) clears every valid slot whose protect flag is 0 and keeps every protected slot.
- R5: A command with cmd_op=1 (targeted flush) clears the slot whose tag equals cmd_addr[31:10], whether or not it is protected. cmd_addr[9:0] is ignored, and other slots are untouched.
- R6: cmd_done is high for exactly the one cycle after each cycle in which cmd_valid is high, and low otherwise.
- R7: A lookup in the same cycle as a flush sees the state after the flush.
- R8: A refill goes to the lowest free slot. A refill whose tag is already held overwrites that slot in place, so no duplicate appears.
- R9: With no free slot, a refill replaces the first unprotected slot at or after a rotating pointer. The pointer then moves to the slot after the replaced one. A protected slot is never replaced.
- R10: When every slot is valid and protected, a refill is dropped and rf_fail is high for the one following cycle.
- R11: Four subpages of one page are four independent slots. A targeted flush of one subpage removes only that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address, 0 on miss |
| rf_valid | input | 1 | Refill request |
| rf_tag | input | 22 | Refill page tag (virtual address bits [31:10]) |
| rf_ppn | input | 22 | Refill physical page number |
| rf_keep | input | 1 | Protect flag for the refilled slot |
| rf_fail | output | 1 | Refill was refused because every slot is protected |
| cmd_valid | input | 1 | Flush command strobe |
| cmd_op | input | 1 | 0 = flush all unprotected, 1 = targeted flush |
| cmd_addr | input | 32 | Address for the targeted flush; bits [9:0] ignored |
| cmd_done | output | 1 | Command completion pulse |

## Verification
The assertions assume that every input is driven to a known value once reset is released. They also assume that cmd_op and cmd_addr are meaningful only while cmd_valid is high, and that rf_tag, rf_ppn and rf_keep are meaningful only while rf_valid is high. The stimulus drives all inputs from time zero, changes them only on falling edges, and drops each strobe after one cycle. It never keeps a command or refill strobe high longer than intended. Same-cycle overlap of a flush and a lookup is driven on purpose, because the ordering rule defines it.

// File: rtl/tlb_preserve.sv
module tlb_preserve #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PG_LSB  = 10,
  parameter int PPN_W   = 22,
  localparam int TAG_W  = VA_W - PG_LSB,
  localparam int PA_W   = PPN_W + PG_LSB,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             rf_valid,
  input  logic [TAG_W-1:0] rf_tag,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_keep,
  output logic             rf_fail,
  input  logic             cmd_valid,
  input  logic             cmd_op,
  input  logic [VA_W-1:0]  cmd_addr,
  output logic             cmd_done
);

  logic [ENTRIES-1:0] vld_q, keep_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;
  logic               done_q, fail_q;

  logic [ENTRIES-1:0] kill, live, lk_m, rf_m, wr;
  logic [PPN_W-1:0]   ppn_sel;
  logic [IDX_W-1:0]   vic;
  logic               vic_ok, use_rr, do_wr;
  logic               unused_sbz;

  wire inv_all = cmd_valid & ~cmd_op;
  wire inv_one = cmd_valid &  cmd_op;

  assign unused_sbz = ^cmd_addr[PG_LSB-1:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign kill[g] = vld_q[g] & ((inv_all & ~keep_q[g]) |
                     (inv_one & (tag_q[g] == cmd_addr[VA_W-1:PG_LSB])));
    assign live[g] = vld_q[g] & ~kill[g];
    assign lk_m[g] = live[g] & (tag_q[g] == lk_vaddr[VA_W-1:PG_LSB]);
    assign rf_m[g] = live[g] & (tag_q[g] == rf_tag);
    assign wr[g]   = do_wr & (vic == IDX_W'(g));
  end

  always_comb begin
    ppn_sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_m[i]) ppn_sel = ppn_sel | ppn_q[i];
  end

  assign lk_hit   = |lk_m;
  assign lk_paddr = lk_hit ? {ppn_sel, lk_vaddr[PG_LSB-1:0]} : '0;

  always_comb begin
    vic    = '0;
    vic_ok = 1'b0;
    use_rr = 1'b0;
    if (|rf_m) begin
      for (int i = 0; i < ENTRIES; i++)
        if (rf_m[i]) begin
          vic    = IDX_W'(i);
          vic_ok = 1'b1;
        end
    end else if (!(&live)) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!live[i]) begin
          vic    = IDX_W'(i);
          vic_ok = 1'b1;
        end
    end else begin
      for (int k = ENTRIES - 1; k >= 0; k--)
        if (!keep_q[(int'(rr_q) + k) % ENTRIES]) begin
          vic    = IDX_W'((int'(rr_q) + k) % ENTRIES);
          vic_ok = 1'b1;
          use_rr = 1'b1;
        end
    end
  end

  assign do_wr = rf_valid & vic_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      keep_q <= '0;
      rr_q   <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= cmd_valid;
      fail_q <= rf_valid & ~vic_ok;
      vld_q  <= live | wr;
      keep_q <= (keep_q & ~kill & ~wr) | (rf_keep ? wr : '0);
      if (do_wr && use_rr)
        rr_q <= (int'(vic) == ENTRIES - 1) ? '0 : vic + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      tag_q[vic] <= rf_tag;
      ppn_q[vic] <= rf_ppn;
    end
  end

  assign cmd_done = done_q;
  assign rf_fail  = fail_q;

endmodule

// File: rtl/tlb_preserve_chk.sv
module tlb_preserve_chk #(
  parameter int VA_W   = 32,
  parameter int PG_LSB = 10,
  parameter int PPN_W  = 22,
  localparam int PA_W  = PPN_W + PG_LSB
) (
  input logic            clk,
  input logic            rst_n,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_hit,
  input logic [PA_W-1:0] lk_paddr,
  input logic            rf_valid,
  input logic            rf_fail,
  input logic            cmd_valid,
  input logic            cmd_op,
  input logic [VA_W-1:0] cmd_addr,
  input logic            cmd_done
);

  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_done);

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !cmd_done);

  a_r10_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rf_fail |-> $past(rf_valid));

  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[PG_LSB-1:0] == lk_vaddr[PG_LSB-1:0]));

  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0));

  a_r7_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op && (lk_vaddr[VA_W-1:PG_LSB] == cmd_addr[VA_W-1:PG_LSB]))
      |-> !lk_hit);

endmodule

bind tlb_preserve tlb_preserve_chk #(.VA_W(VA_W), .PG_LSB(PG_LSB), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
  .rf_valid(rf_valid), .rf_fail(rf_fail), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .cmd_done(cmd_done)
);

// File: tb/sim_tlb_preserve.sv
module sim_tlb_preserve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        rf_valid = 1'b0;
  logic [21:0] rf_tag = '0;
  logic [21:0] rf_ppn = '0;
  logic        rf_keep = 1'b0;
  logic        rf_fail;
  logic        cmd_valid = 1'b0;
  logic        cmd_op = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic        cmd_done;

  tlb_preserve u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    int          kind;
    logic        exp_bit;
    logic [31:0] exp_pa;
    string       req;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  function automatic logic [31:0] pa(input logic [21:0] ppn, input logic [31:0] va);
    return {ppn, va[9:0]};
  endfunction

  function automatic void push(input int kind, input logic b, input logic [31:0] p, input string req);
    item_t it;
    it.kind = kind; it.exp_bit = b; it.exp_pa = p; it.req = req;
    q.push_back(it);
  endfunction

  initial forever begin
    @(negedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      case (it.kind)
        0: if (lk_hit !== it.exp_bit || lk_paddr !== it.exp_pa) begin
             bad++;
             $display("FAIL %s lookup: hit=%b pa=%h expected hit=%b pa=%h",
                      it.req, lk_hit, lk_paddr, it.exp_bit, it.exp_pa);
           end
        1: if (cmd_done !== it.exp_bit) begin
             bad++;
             $display("FAIL %s cmd_done=%b expected %b", it.req, cmd_done, it.exp_bit);
           end
        default: if (rf_fail !== it.exp_bit) begin
             bad++;
             $display("FAIL %s rf_fail=%b expected %b", it.req, rf_fail, it.exp_bit);
           end
      endcase
    end
  end

  task automatic look(input logic [31:0] va, input logic h, input logic [21:0] ppn, input string req);
    @(negedge clk);
    lk_vaddr = va;
    push(0, h, h ? pa(ppn, va) : 32'h0, req);
  endtask

  task automatic refill(input logic [31:0] va, input logic [21:0] ppn, input logic keep,
                        input logic exp_fail, input bit pulse_chk, input string req);
    @(negedge clk);
    rf_valid = 1'b1; rf_tag = va[31:10]; rf_ppn = ppn; rf_keep = keep;
    @(negedge clk);
    rf_valid = 1'b0;
    push(2, exp_fail, 32'h0, req);
    if (pulse_chk) begin
      @(negedge clk);
      push(2, 1'b0, 32'h0, req);
    end
  endtask

  task automatic flush(input logic op, input logic [31:0] addr, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
    push(1, 1'b1, 32'h0, req);
    @(negedge clk);
    push(1, 1'b0, 32'h0, req);
  endtask

  task automatic flush_look(input logic op, input logic [31:0] addr, input logic [31:0] va,
                            input logic h, input logic [21:0] ppn, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; lk_vaddr = va;
    push(0, h, h ? pa(ppn, va) : 32'h0, req);
    @(negedge clk);
    cmd_valid = 1'b0;
    push(1, 1'b1, 32'h0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    push(1, 1'b0, 32'h0, "R1");
    look(32'h1234_5678, 0, 0, "R1");
    @(negedge clk); push(2, 1'b0, 32'h0, "R1");
    // R2 / R3 basic translation and granule
    refill(32'h0000_0400, 22'h0AB, 0, 0, 0, "R8");
    look(32'h0000_07FF, 1, 22'h0AB, "R2");
    look(32'h0000_0400, 1, 22'h0AB, "R3");
    look(32'h0000_0800, 0, 0, "R3");
    // R11 subpages
    refill(32'h0000_1000, 22'h010, 0, 0, 0, "R11");
    refill(32'h0000_1400, 22'h011, 0, 0, 0, "R11");
    refill(32'h0000_1800, 22'h012, 0, 0, 0, "R11");
    refill(32'h0000_1C00, 22'h013, 0, 0, 0, "R11");
    flush(1, 32'h0000_1555, "R5");
    look(32'h0000_1400, 0, 0, "R11");
    look(32'h0000_1000, 1, 22'h010, "R11");
    look(32'h0000_1A04, 1, 22'h012, "R11");
    look(32'h0000_1C00, 1, 22'h013, "R11");
    flush(1, 32'h0000_1000, "R11");
    flush(1, 32'h0000_1800, "R11");
    flush(1, 32'h0000_1C00, "R11");
    look(32'h0000_1C00, 0, 0, "R11");
    // R4 flush-all keeps protected slots
    refill(32'h8000_0000, 22'h200, 1, 0, 0, "R4");
    refill(32'h9000_0000, 22'h300, 0, 0, 0, "R4");
    flush(0, 32'h0, "R4");
    look(32'h8000_0010, 1, 22'h200, "R4");
    look(32'h9000_0000, 0, 0, "R4");
    look(32'h0000_0400, 0, 0, "R4");
    // R5 targeted flush removes a protected slot
    flush(1, 32'h8000_0000, "R5");
    look(32'h8000_0010, 0, 0, "R5");
    // R7 flush before lookup in the same cycle
    refill(32'hA000_0000, 22'h055, 0, 0, 0, "R7");
    look(32'hA000_0000, 1, 22'h055, "R7");
    flush_look(1, 32'hA000_0000, 32'hA000_0123, 0, 0, "R7");
    look(32'hA000_0000, 0, 0, "R7");
    // R8 in-place overwrite
    refill(32'hB000_0000, 22'h011, 0, 0, 0, "R8");
    refill(32'hB000_0000, 22'h022, 0, 0, 0, "R8");
    look(32'hB000_0004, 1, 22'h022, "R8");
    flush(1, 32'hB000_0000, "R8");
    look(32'hB000_0004, 0, 0, "R8");
    // R9 rotating replacement
    for (int i = 0; i < 6; i++)
      refill(32'hC000_0000 + 32'(i) * 32'h400, 22'h100 + 22'(i), 1, 0, 0, "R1");
    refill(32'hD000_0000, 22'h1F6, 0, 0, 0, "R1");
    refill(32'hD000_0400, 22'h1F7, 0, 0, 0, "R1");
    look(32'hD000_0400, 1, 22'h1F7, "R1");
    refill(32'hE000_0000, 22'h031, 0, 0, 0, "R9");
    look(32'hD000_0000, 0, 0, "R9");
    look(32'hE000_0000, 1, 22'h031, "R9");
    look(32'hD000_0400, 1, 22'h1F7, "R9");
    refill(32'hE000_0400, 22'h032, 0, 0, 0, "R9");
    look(32'hD000_0400, 0, 0, "R9");
    look(32'hC000_0000, 1, 22'h100, "R9");
    look(32'hC000_1400, 1, 22'h105, "R9");
    refill(32'hE000_0800, 22'h033, 0, 0, 0, "R9");
    look(32'hE000_0000, 0, 0, "R9");
    look(32'hE000_0400, 1, 22'h032, "R9");
    look(32'hE000_0800, 1, 22'h033, "R9");
    // R10 all protected
    refill(32'hF000_0000, 22'h3F0, 1, 0, 0, "R9");
    look(32'hE000_0400, 0, 0, "R9");
    refill(32'hF000_0400, 22'h3F1, 1, 0, 0, "R9");
    look(32'hE000_0800, 0, 0, "R9");
    refill(32'hF000_0800, 22'h3F2, 0, 1, 1, "R10");
    look(32'hF000_0800, 0, 0, "R10");
    look(32'hF000_0400, 1, 22'h3F1, "R10");
    flush(0, 32'h0, "R4");
    look(32'hC000_0000, 1, 22'h100, "R4");
    refill(32'hF000_0800, 22'h3F2, 0, 1, 0, "R10");
    flush(1, 32'hC000_0000, "R5");
    refill(32'hF000_0800, 22'h3F2, 0, 0, 0, "R10");
    look(32'hF000_0BFF, 1, 22'h3F2, "R10");
    look(32'hC000_0000, 0, 0, "R5");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule